// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Serial Port

This block carries 8-bit companded voice samples for two independent channels over one transmit serial line and one receive serial line. There is no slot-number register. Each channel has its own transmit sync input and its own receive sync input. The rising edge of a sync marks the start of that channel's 8-bit slot in that direction. Slots may start on any bit clock, so they need not fall on byte boundaries. The transmit and receive syncs of a channel may be tied together or driven separately.

The transmit byte of a channel is read from a parallel input and sent MSB first. A received byte is assembled MSB first into a parallel output register, and a one-cycle valid strobe for that channel marks each new byte. The mode input `timing_delayed` sets where the data starts. When it is high, the first bit starts one bit clock after the sync edge. When it is low, the first bit starts in the same bit clock as the sync edge. The transmit line carries an output enable so that a pad or an external bus driver can release it between slots. A collision flag for each direction reports any bit period in which both channels' slots are active at once.

Top module: `pcm_slot_port`

## Requirements
- R1: After a synchronous active-low reset, `tx_oe`, `tx_sd`, `rx_valid`, `rx_samples`, `tx_collide` and `rx_collide` are all 0.
- R2: When `timing_delayed`=1 and a rising edge of `tx_fs[ch]` is seen in bit cycle n, the byte of channel ch (`tx_samples[8*ch+7:8*ch]`) appears on `tx_sd` MSB first in cycles n+1 to n+8, and `tx_oe` is 1 in those cycles.
- R3: When `timing_delayed`=0, the same byte appears MSB first in cycles n to n+7, and the MSB is taken directly from `tx_samples` during cycle n.
- R4: The transmit byte is latched in the sync-edge cycle n. A change of `tx_samples` for that channel after cycle n does not change the bits sent in that slot.
- R5: When `timing_delayed`=1 and a rising edge of `rx_fs[ch]` is seen in cycle n, `rx_sd` is sampled on the falling clock edge in cycles n+1 to n+8, MSB first. The byte is shown on `rx_samples[8*ch+7:8*ch]` from cycle n+9, and `rx_valid[ch]` is 1 for cycle n+9 only.
- R6: When `timing_delayed`=0, `rx_sd` is sampled in cycles n to n+7, and the byte and the one-cycle `rx_valid[ch]` pulse appear in cycle n+8.
- R7: Outside every active transmit slot, `tx_oe` is 0 and `tx_sd` is driven 0.
- R8: A sync held high for several cycles starts one slot only. Only a low-to-high transition starts a slot.
- R9: `tx_collide` (or `rx_collide`) is 1 in the cycle after any cycle in which both channels' transmit (or receive) slots are active. While both transmit slots are active, channel 0's bit is driven on `tx_sd`.
- R10: The output byte of a channel holds its value until that channel's next capture. A capture on the other channel does not change it.
- R11: The two channels and the two directions run independently. Slots may start on any bit cycle, and the transmit and receive syncs may be tied together or separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one bit per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_delayed | input | 1 | 1: data starts one cycle after the sync edge; 0: data starts in the sync-edge cycle |
| tx_fs | input | NUM_CH | Per-channel transmit slot sync |
| rx_fs | input | NUM_CH | Per-channel receive slot sync |
| tx_samples | input | NUM_CH*SLOT_BITS | Transmit bytes, channel ch at bits [8ch+7:8ch] |
| rx_sd | input | 1 | Receive serial data, sampled on the falling edge |
| tx_sd | output | 1 | Transmit serial data, 0 when idle |
| tx_oe | output | 1 | Transmit output enable, 1 during any active transmit slot |
| rx_samples | output | NUM_CH*SLOT_BITS | Last received byte for each channel |
| rx_valid | output | NUM_CH | One-cycle strobe for each channel when a new byte is captured |
| tx_collide | output | 1 | Both transmit slots were active in the previous cycle |
| rx_collide | output | 1 | Both receive slots were active in the previous cycle |

## Verification
Counting from the cycle in which a sync edge is seen, the transmit bits are due from the same cycle in non-delayed mode and from the next cycle in delayed mode. The receive byte and its strobe are due eight cycles after the first data cycle, and the collision flags one cycle after the overlap. The bench drives inputs 1 ns after each rising edge, so the receive bit is settled well before the falling edge that samples it. It samples outputs 3 ns after the rising edge. For every cycle of a frame, it computes from the sync start positions which result is due in that cycle and compares the outputs against that expectation.

// File: rtl/pcm_slot_pkg.sv
// Package: shared constants for the dual-channel PCM slot port.
// Assumes: one bit per clock, fixed-size slots, MSB first.
package pcm_slot_pkg;
    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_NUM_CH    = 2;

    typedef enum logic {
        ALIGN_SAME_CYCLE = 1'b0,
        ALIGN_NEXT_CYCLE = 1'b1
    } align_e;
endpackage

// File: rtl/pcm_slot_timer.sv
// Module: pcm_slot_timer
// Finds the rising edge of one sync input and tracks which bit of the
// slot is current. In the sync-edge cycle of same-cycle mode it reports the
// MSB combinationally; otherwise a down-counter holds the bits still to go.
// Assumes: the sync has been low for at least one cycle before each edge.
module pcm_slot_timer #(
    parameter int SLOT_BITS = pcm_slot_pkg::DEF_SLOT_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  pcm_slot_pkg::align_e         align,
    input  logic                         fs,
    output logic                         rise,
    output logic                         early,
    output logic                         active,
    output logic [$clog2(SLOT_BITS)-1:0] bit_idx
);
    localparam int REM_W = $clog2(SLOT_BITS + 1);
    localparam int IDX_W = $clog2(SLOT_BITS);

    logic             fs_q;
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] idx_src;

    // Edge detect and current-bit decode.
    always_comb begin
        rise    = fs & ~fs_q;
        early   = rise && (align == pcm_slot_pkg::ALIGN_SAME_CYCLE);
        active  = (rem_q != '0) || early;
        idx_src = early ? REM_W'(SLOT_BITS) : rem_q;
        bit_idx = IDX_W'(idx_src - REM_W'(1));
    end

    // Remembers the last sync level and counts down the slot bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            rem_q <= '0;
        end else begin
            fs_q <= fs;
            if (rise) begin
                rem_q <= (align == pcm_slot_pkg::ALIGN_NEXT_CYCLE)
                         ? REM_W'(SLOT_BITS) : REM_W'(SLOT_BITS - 1);
            end else if (rem_q != '0) begin
                rem_q <= rem_q - REM_W'(1);
            end
        end
    end

    p_rem_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= REM_W'(SLOT_BITS));
    p_next_cycle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && align == pcm_slot_pkg::ALIGN_NEXT_CYCLE) |=> (rem_q == REM_W'(SLOT_BITS)));
    p_level_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fs && fs_q && rem_q == '0) |=> (rem_q == '0));
endmodule

// File: rtl/pcm_tx_lane.sv
// Module: pcm_tx_lane
// Holds one channel's transmit byte for the length of its slot and selects
// the current bit. In the sync-edge cycle of same-cycle mode the MSB comes
// straight from the parallel input, because the copy is not yet loaded.
// Assumes: byte_in is stable during the sync-edge cycle.
module pcm_tx_lane #(
    parameter int SLOT_BITS = pcm_slot_pkg::DEF_SLOT_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise,
    input  logic                         early,
    input  logic                         active,
    input  logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    input  logic [SLOT_BITS-1:0]         byte_in,
    output logic                         bit_out
);
    logic [SLOT_BITS-1:0] shadow_q;

    // Loads the byte on the sync edge so later input changes cannot reach the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rise) begin
            shadow_q <= byte_in;
        end
    end

    // Selects the bit for the current cycle, 0 when the slot is inactive.
    always_comb begin
        if (!active)     bit_out = 1'b0;
        else if (early)  bit_out = byte_in[SLOT_BITS-1];
        else             bit_out = shadow_q[bit_idx];
    end

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bit_out);
endmodule

// File: rtl/pcm_rx_lane.sv
// Module: pcm_rx_lane
// Shifts one channel's receive bits in, MSB first, and publishes the byte
// with a one-cycle strobe after the last bit.
// Assumes: line_bit already holds the bit sampled on the falling edge.
module pcm_rx_lane #(
    parameter int SLOT_BITS = pcm_slot_pkg::DEF_SLOT_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         active,
    input  logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    input  logic                         line_bit,
    output logic [SLOT_BITS-1:0]         byte_out,
    output logic                         valid
);
    logic [SLOT_BITS-1:0] shift_q;
    logic [SLOT_BITS-1:0] shift_nx;

    // Next value of the shift register with the new bit appended.
    always_comb shift_nx = {shift_q[SLOT_BITS-2:0], line_bit};

    // Shifts during the slot and publishes the byte on the LSB cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (active) begin
                shift_q <= shift_nx;
                if (bit_idx == '0) begin
                    byte_out <= shift_nx;
                    valid    <= 1'b1;
                end
            end
        end
    end

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(byte_out));
endmodule

// File: rtl/pcm_slot_port.sv
// Module: pcm_slot_port (top)
// Two-channel PCM time-slot serial port. Each channel and direction has its
// own slot timer. The transmit lanes are merged onto one line, with channel 0
// first when slots overlap, and the receive line is sampled on the falling edge.
// Assumes: the syncs are generated from clk; the mode stays fixed within a frame.
module pcm_slot_port #(
    parameter int SLOT_BITS = pcm_slot_pkg::DEF_SLOT_BITS,
    parameter int NUM_CH    = pcm_slot_pkg::DEF_NUM_CH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          timing_delayed,
    input  logic [NUM_CH-1:0]             tx_fs,
    input  logic [NUM_CH-1:0]             rx_fs,
    input  logic [NUM_CH*SLOT_BITS-1:0]   tx_samples,
    input  logic                          rx_sd,
    output logic                          tx_sd,
    output logic                          tx_oe,
    output logic [NUM_CH*SLOT_BITS-1:0]   rx_samples,
    output logic [NUM_CH-1:0]             rx_valid,
    output logic                          tx_collide,
    output logic                          rx_collide
);
    localparam int IDX_W = $clog2(SLOT_BITS);

    pcm_slot_pkg::align_e align;
    logic [NUM_CH-1:0]    tx_rise, tx_early, tx_act, tx_lane_bit;
    logic [NUM_CH-1:0]    rx_rise, rx_early, rx_act;
    logic [IDX_W-1:0]     tx_idx [NUM_CH];
    logic [IDX_W-1:0]     rx_idx [NUM_CH];
    logic                 line_q;

    // Turns the mode pin into the alignment type.
    always_comb align = timing_delayed ? pcm_slot_pkg::ALIGN_NEXT_CYCLE
                                       : pcm_slot_pkg::ALIGN_SAME_CYCLE;

    // Samples the receive line in the middle of each bit cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= rx_sd;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pcm_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_tx_tmr (
            .clk(clk), .rst_n(rst_n), .align(align), .fs(tx_fs[ch]),
            .rise(tx_rise[ch]), .early(tx_early[ch]), .active(tx_act[ch]),
            .bit_idx(tx_idx[ch]));
        pcm_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_rx_tmr (
            .clk(clk), .rst_n(rst_n), .align(align), .fs(rx_fs[ch]),
            .rise(rx_rise[ch]), .early(rx_early[ch]), .active(rx_act[ch]),
            .bit_idx(rx_idx[ch]));
        pcm_tx_lane #(.SLOT_BITS(SLOT_BITS)) u_tx_lane (
            .clk(clk), .rst_n(rst_n), .rise(tx_rise[ch]), .early(tx_early[ch]),
            .active(tx_act[ch]), .bit_idx(tx_idx[ch]),
            .byte_in(tx_samples[ch*SLOT_BITS +: SLOT_BITS]),
            .bit_out(tx_lane_bit[ch]));
        pcm_rx_lane #(.SLOT_BITS(SLOT_BITS)) u_rx_lane (
            .clk(clk), .rst_n(rst_n), .active(rx_act[ch]), .bit_idx(rx_idx[ch]),
            .line_bit(line_q),
            .byte_out(rx_samples[ch*SLOT_BITS +: SLOT_BITS]),
            .valid(rx_valid[ch]));

        p_rx_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[ch] |-> $past(rx_act[ch]));
    end

    // Merges the lanes onto the shared line; the lowest active channel wins.
    always_comb begin
        tx_sd = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (tx_act[i]) tx_sd = tx_lane_bit[i];
        end
        tx_oe = |tx_act;
    end

    // Registers a flag for any cycle with more than one slot active per direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_collide <= 1'b0;
            rx_collide <= 1'b0;
        end else begin
            tx_collide <= |(tx_act & (tx_act - NUM_CH'(1)));
            rx_collide <= |(rx_act & (rx_act - NUM_CH'(1)));
        end
    end

    p_idle_line_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_sd);
    p_tx_collide_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_collide |-> ($past($countones(tx_act)) > 1));
    p_rx_collide_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_collide |-> ($past($countones(rx_act)) > 1));
endmodule

// File: tb/pcm_slot_port_test.sv
// Bench for pcm_slot_port: directed frames plus seeded random frames.
// Expected line bits, strobes and flags come from the sync start positions.
module pcm_slot_port_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        timing_delayed;
    logic [1:0]  tx_fs, rx_fs;
    logic [15:0] tx_samples;
    logic        rx_sd;
    logic        tx_sd, tx_oe, tx_collide, rx_collide;
    logic [15:0] rx_samples;
    logic [1:0]  rx_valid;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] exp_rx [2];

    always #2 clk = ~clk;

    pcm_slot_port uut (
        .clk(clk), .rst_n(rst_n), .timing_delayed(timing_delayed),
        .tx_fs(tx_fs), .rx_fs(rx_fs), .tx_samples(tx_samples), .rx_sd(rx_sd),
        .tx_sd(tx_sd), .tx_oe(tx_oe), .rx_samples(rx_samples),
        .rx_valid(rx_valid), .tx_collide(tx_collide), .rx_collide(rx_collide));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input int c, input int d);
        return (c >= d) && (c < d + 8);
    endfunction

    // One frame: sync starts per channel and direction, sync width, length.
    task automatic run_frame(input bit dly, input int txs0, input int txs1,
                             input int rxs0, input int rxs1, input int w,
                             input int flen, input string ftag);
        int txs [2];
        int rxs [2];
        int txd [2];
        int rxd [2];
        logic [7:0] tb [2];
        logic [7:0] rb [2];
        logic       line_bits [64];
        string      txreq;
        string      rxreq;
        txs[0] = txs0; txs[1] = txs1; rxs[0] = rxs0; rxs[1] = rxs1;
        for (int ch = 0; ch < 2; ch++) begin
            txd[ch] = txs[ch] + (dly ? 1 : 0);
            rxd[ch] = rxs[ch] + (dly ? 1 : 0);
            tb[ch]  = 8'($urandom);
            rb[ch]  = 8'($urandom);
        end
        txreq = dly ? "R2 R4" : "R3 R4";
        rxreq = dly ? "R5" : "R6";
        for (int c = 0; c < flen; c++) begin
            @(posedge clk);
            #1;
            timing_delayed = dly;
            for (int ch = 0; ch < 2; ch++) begin
                tx_fs[ch] = (c >= txs[ch]) && (c < txs[ch] + w);
                rx_fs[ch] = (c >= rxs[ch]) && (c < rxs[ch] + w);
                tx_samples[ch*8 +: 8] = (c <= txs[ch]) ? tb[ch] : 8'($urandom);
            end
            if (in_win(c, rxd[0]))      rx_sd = rb[0][7 - (c - rxd[0])];
            else if (in_win(c, rxd[1])) rx_sd = rb[1][7 - (c - rxd[1])];
            else                        rx_sd = 1'($urandom);
            line_bits[c] = rx_sd;
            #2;
            // Transmit line, channel 0 first on overlap (R9), idle low (R7).
            if (in_win(c, txd[0])) begin
                check({txreq, " R9 ", ftag}, "tx_oe", 32'(tx_oe), 32'd1);
                check({txreq, " R9 ", ftag}, "tx_sd ch0", 32'(tx_sd), 32'(tb[0][7 - (c - txd[0])]));
            end else if (in_win(c, txd[1])) begin
                check({txreq, " ", ftag}, "tx_oe", 32'(tx_oe), 32'd1);
                check({txreq, " ", ftag}, "tx_sd ch1", 32'(tx_sd), 32'(tb[1][7 - (c - txd[1])]));
            end else begin
                check({"R7 R8 ", ftag}, "tx_oe idle", 32'(tx_oe), 32'd0);
                check({"R7 R8 ", ftag}, "tx_sd idle", 32'(tx_sd), 32'd0);
            end
            check({"R9 ", ftag}, "tx_collide", 32'(tx_collide),
                  32'(c >= 1 && in_win(c - 1, txd[0]) && in_win(c - 1, txd[1])));
            check({"R9 ", ftag}, "rx_collide", 32'(rx_collide),
                  32'(c >= 1 && in_win(c - 1, rxd[0]) && in_win(c - 1, rxd[1])));
            // Receive strobes and held bytes (R5 R6 R10).
            for (int ch = 0; ch < 2; ch++) begin
                if (c == rxd[ch] + 8) begin
                    for (int k = 0; k < 8; k++) exp_rx[ch][7 - k] = line_bits[rxd[ch] + k];
                end
                check({rxreq, " R8 ", ftag}, "rx_valid", 32'(rx_valid[ch]), 32'(c == rxd[ch] + 8));
                check({rxreq, " R10 ", ftag}, "rx_samples", 32'(rx_samples[ch*8 +: 8]), 32'(exp_rx[ch]));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; timing_delayed = 1'b1; tx_fs = '0; rx_fs = '0;
        tx_samples = '0; rx_sd = 1'b0;
        exp_rx[0] = '0; exp_rx[1] = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        // R1: reset state.
        check("R1", "tx_oe", 32'(tx_oe), 32'd0);
        check("R1", "tx_sd", 32'(tx_sd), 32'd0);
        check("R1", "rx_valid", 32'(rx_valid), 32'd0);
        check("R1", "rx_samples", 32'(rx_samples), 32'd0);
        check("R1", "tx_collide", 32'(tx_collide), 32'd0);
        check("R1", "rx_collide", 32'(rx_collide), 32'd0);

        // Directed: tied syncs, both modes (R11).
        run_frame(1'b1, 2, 20, 2, 20, 1, 56, "R11");
        run_frame(1'b0, 0, 8, 0, 8, 1, 56, "R11");
        // Sync held high well past the slot (R8).
        run_frame(1'b1, 3, 25, 5, 30, 12, 56, "R8");
        run_frame(1'b0, 3, 25, 5, 30, 12, 56, "R8");
        // Overlapping slots in both directions (R9).
        run_frame(1'b1, 4, 7, 10, 13, 2, 56, "R9");
        run_frame(1'b0, 20, 22, 21, 26, 1, 56, "R9");

        // Random frames with independent, unaligned starts (R11).
        for (int f = 0; f < 40; f++) begin
            int t0, t1, r0, r1, wd;
            bit md;
            md = 1'($urandom);
            t0 = $urandom % 40;
            do t1 = $urandom % 40; while ((t1 - t0 < 8) && (t0 - t1 < 8));
            if (($urandom % 4) == 0) begin
                r0 = t0; r1 = t1;
            end else begin
                r0 = $urandom % 40;
                do r1 = $urandom % 40; while ((r1 - r0 < 8) && (r0 - r1 < 8));
            end
            wd = 1 + ($urandom % 6);
            run_frame(md, t0, t1, r0, r1, wd, 56, "R11");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule